// File: doc/BRIEF.md
# Producer-Consumer Latency Interlock

This block is an issue-stage interlock for an in-order pipeline. For each destination register it tracks how long ago that register's most recent producer issued, and which class of operation the producer was. A consumer presents its operation class and up to two source registers. Each source carries a flag that says whether it feeds an address computation or is only data to be stored. The block raises `stall` while any valid source is still too young for that consumer.

The wait is chosen per producer/consumer pair, not per producer alone. A value feeding an address needs several more cycles than the same value feeding an execute-pipe operation. A loaded value written straight back to memory needs no wait at all.

Each register holds a small down-counter and the class of its producer. The counter is loaded at issue. The lookup compares the counter against the pair's latency.

Latency L means the following: if a producer issues in cycle t and a consumer is presented in cycle t+k, the consumer stalls exactly when k < L. The case k = 0 covers a consumer presented in the same cycle as its producer. No data is stored or forwarded.

Top module: `lat_interlock`

## Requirements
- R1: After reset every register is ready. No lookup stalls until a producer is issued.
- R2: A producer issued in cycle t (iss_vld=1, class iss_cls, register iss_dst) makes a consumer of source register iss_dst, presented in cycle t+k, stall if and only if k < L. L is the latency of that producer/consumer pair. A lookup in cycle t itself that names iss_dst is checked against the producer being issued in that cycle.
- R3: Load producer (code 0): the latency is 3 to an address use, 0 to store data, and 1 to every other consumer.
- R4: Integer ALU producer (code 1): the latency is 5 to an address use and 1 to every other consumer, including store data.
- R5: Multiply producers. For the 32-bit multiply (code 2), the latency is 7 to an address use and 3 otherwise. For the 64-bit multiply (code 3), it is 7 to an address use, 3 to a read of the low result, and 4 to a read of the high result and to all other consumers.
- R6: Move-to-hi/lo producer (code 4): the latency is 3 to a high or low result read and 4 to all other consumers, including multiply/divide.
- R7: The following producers have the same latency for every consumer: basic FP operation (code 5) 4, FP multiply-add or second reciprocal/square-root step (code 6) 8, integer-to-FP transfer (code 7) 5, FP-to-integer transfer (code 8) 1.
- R8: Long FP producers have the same latency for every consumer: divide single 24 (code 9), divide double 32 (10), square root single 28 (11), square root double 40 (12), reciprocal single 12 (13), reciprocal double 20 (14), reciprocal square root single 16 (15), reciprocal square root double 28 (16).
- R9: Consumer classes are execute 0, multiply/divide 1, high result read 2, low result read 3, and memory 4. Codes 5 to 7 act as execute. A source's address flag selects address use (1) or store data (0) only in memory class. In every other class the flag has no effect.
- R10: A source whose valid bit is 0 never causes a stall. `stall` is the OR of the two sources' stalls.
- R11: A newer producer to a register replaces the pending one. This holds whether the newer producer is shorter or longer than the pending one.
- R12: Issuing to one register does not change the readiness of any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 1 | A producer issues this cycle |
| iss_cls | input | 5 | Producer class code |
| iss_dst | input | AW = log2(NREG) | Producer destination register |
| use_cls | input | 3 | Consumer class code |
| src_a | input | AW | First source register |
| src_a_vld | input | 1 | First source is used |
| src_a_addr | input | 1 | First source is an address (memory class only) |
| src_b | input | AW | Second source register |
| src_b_vld | input | 1 | Second source is used |
| src_b_addr | input | 1 | Second source is an address (memory class only) |
| stall | output | 1 | Some valid source is not yet ready |

## Verification
The bench builds the block with NREG = 8 and the default 6-bit counter. Every register is therefore revisited often, and write-after-write replacement happens frequently during the random phase. The 6-bit counter still holds the longest latency of 40, so every counter is swept from load to zero. This covers every producer/consumer pair at each cycle distance from 0 past its latency.

// File: rtl/lat_interlock.sv
module lat_interlock #(
  parameter int NREG = 32,
  parameter int CW = 6,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_vld,
  input  logic [4:0]    iss_cls,
  input  logic [AW-1:0] iss_dst,
  input  logic [2:0]    use_cls,
  input  logic [AW-1:0] src_a,
  input  logic          src_a_vld,
  input  logic          src_a_addr,
  input  logic [AW-1:0] src_b,
  input  logic          src_b_vld,
  input  logic          src_b_addr,
  output logic          stall
);

  localparam logic [2:0] K_EXEC = 3'd0, K_RDHI = 3'd2, K_RDLO = 3'd3,
                         K_ADDR = 3'd4, K_SDATA = 3'd5;

  logic [CW-1:0] cnt_q [NREG];
  logic [4:0]    cls_q [NREG];

  function automatic logic [CW-1:0] lmax_f(input logic [4:0] p);
    case (p)
      5'd0:        return CW'(3);
      5'd1:        return CW'(5);
      5'd2, 5'd3:  return CW'(7);
      5'd4, 5'd5:  return CW'(4);
      5'd6:        return CW'(8);
      5'd7:        return CW'(5);
      5'd8:        return CW'(1);
      5'd9:        return CW'(24);
      5'd10:       return CW'(32);
      5'd11:       return CW'(28);
      5'd12:       return CW'(40);
      5'd13:       return CW'(12);
      5'd14:       return CW'(20);
      5'd15:       return CW'(16);
      5'd16:       return CW'(28);
      default:     return CW'(1);
    endcase
  endfunction

  function automatic logic [CW-1:0] lat_f(input logic [4:0] p, input logic [2:0] k);
    case (p)
      5'd0:    return (k == K_ADDR) ? CW'(3) : (k == K_SDATA) ? CW'(0) : CW'(1);
      5'd1:    return (k == K_ADDR) ? CW'(5) : CW'(1);
      5'd2:    return (k == K_ADDR) ? CW'(7) : CW'(3);
      5'd3:    return (k == K_ADDR) ? CW'(7) : (k == K_RDLO) ? CW'(3) : CW'(4);
      5'd4:    return (k == K_RDHI || k == K_RDLO) ? CW'(3) : CW'(4);
      default: return lmax_f(p);
    endcase
  endfunction

  function automatic logic [2:0] kind_f(input logic [2:0] c, input logic addr);
    if (c == 3'd4) return addr ? K_ADDR : K_SDATA;
    if (c < 3'd4)  return c;
    return K_EXEC;
  endfunction

  function automatic logic must_wait(input logic [CW-1:0] c, input logic [4:0] p,
                                     input logic [2:0] k);
    logic [CW:0] sum;
    sum = {1'b0, c} + {1'b0, lat_f(p, k)};
    return sum > {1'b0, lmax_f(p)};
  endfunction

  wire hit_a = iss_vld && (iss_dst == src_a);
  wire hit_b = iss_vld && (iss_dst == src_b);

  wire [CW-1:0] c_a = hit_a ? lmax_f(iss_cls) : cnt_q[src_a];
  wire [CW-1:0] c_b = hit_b ? lmax_f(iss_cls) : cnt_q[src_b];
  wire [4:0]    p_a = hit_a ? iss_cls : cls_q[src_a];
  wire [4:0]    p_b = hit_b ? iss_cls : cls_q[src_b];

  wire wait_a = src_a_vld && must_wait(c_a, p_a, kind_f(use_cls, src_a_addr));
  wire wait_b = src_b_vld && must_wait(c_b, p_b, kind_f(use_cls, src_b_addr));

  assign stall = wait_a || wait_b;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n) begin
        cnt_q[i] <= '0;
        cls_q[i] <= '0;
      end else if (iss_vld && iss_dst == AW'(i)) begin
        cnt_q[i] <= lmax_f(iss_cls) - CW'(1);
        cls_q[i] <= iss_cls;
      end else if (cnt_q[i] != '0) begin
        cnt_q[i] <= cnt_q[i] - CW'(1);
      end
    end
  end

endmodule

// File: rtl/lat_interlock_chk.sv
module lat_interlock_chk #(
  parameter int NREG = 32,
  parameter int CW = 6,
  localparam int AW = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_vld,
  input logic [4:0]    iss_cls,
  input logic [AW-1:0] iss_dst,
  input logic [2:0]    use_cls,
  input logic [AW-1:0] src_a,
  input logic          src_a_vld,
  input logic          src_a_addr,
  input logic [AW-1:0] src_b,
  input logic          src_b_vld,
  input logic          src_b_addr,
  input logic          stall
);

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) && !iss_vld |-> !stall);

  p_no_valid_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !src_a_vld && !src_b_vld |-> !stall);

  p_alu_coissue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld && iss_cls == 5'd1 && src_a_vld && src_a == iss_dst && use_cls == 3'd0 |-> stall);

  p_load_store_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(iss_vld && iss_cls == 5'd0) && use_cls == 3'd4 &&
    src_a_vld && !src_a_addr && !src_b_vld && src_a == $past(iss_dst) &&
    !(iss_vld && iss_dst == src_a) |-> !stall);

  p_mul_address_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(iss_vld && iss_cls == 5'd2) && use_cls == 3'd4 &&
    src_a_vld && src_a_addr && src_a == $past(iss_dst) |-> stall);

endmodule

bind lat_interlock lat_interlock_chk #(.NREG(NREG), .CW(CW)) u_chk (.*);

// File: tb/sim_lat_interlock.sv
`timescale 1ns/1ps
module sim_lat_interlock;
  localparam int BN = 8;
  localparam int BA = $clog2(BN);

  logic clk = 0, rst_n = 0;
  logic iss_vld = 0, src_a_vld = 0, src_a_addr = 0, src_b_vld = 0, src_b_addr = 0;
  logic [4:0] iss_cls = '0;
  logic [BA-1:0] iss_dst = '0, src_a = '0, src_b = '0;
  logic [2:0] use_cls = '0;
  logic stall;

  int checks = 0, errors = 0, cyc = 0;
  int itime [BN];
  int pcls [BN];

  always #10 clk = ~clk;

  lat_interlock #(.NREG(BN), .CW(6)) u0 (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_cls(iss_cls), .iss_dst(iss_dst),
    .use_cls(use_cls), .src_a(src_a), .src_a_vld(src_a_vld), .src_a_addr(src_a_addr),
    .src_b(src_b), .src_b_vld(src_b_vld), .src_b_addr(src_b_addr), .stall(stall));

  // consumer kinds: 0 exec, 1 muldiv, 2 hi read, 3 lo read, 4 address, 5 store data
  function automatic int want(int p, int k);
    if (p == 0) begin
      if (k == 4) return 3;
      if (k == 5) return 0;
      return 1;
    end
    if (p == 1) return (k == 4) ? 5 : 1;
    if (p == 2) return (k == 4) ? 7 : 3;
    if (p == 3) begin
      if (k == 4) return 7;
      if (k == 3) return 3;
      return 4;
    end
    if (p == 4) return (k == 2 || k == 3) ? 3 : 4;
    case (p)
      5: return 4;   6: return 8;   7: return 5;   8: return 1;
      9: return 24;  10: return 32; 11: return 28; 12: return 40;
      13: return 12; 14: return 20; 15: return 16; 16: return 28;
      default: return 1;
    endcase
  endfunction

  function automatic bit src_busy(bit iv, int ip, int id, int c, int s, bit v, bit ad);
    int k, age, p;
    if (!v) return 0;
    k = (c == 4) ? (ad ? 4 : 5) : ((c < 4) ? c : 0);
    if (iv && id == s) begin age = 0; p = ip; end
    else begin age = cyc - itime[s]; p = pcls[s]; end
    return age < want(p, k);
  endfunction

  task automatic step(bit iv, int ip, int id, int c, int sa, bit va, bit aa,
                      int sb, bit vb, bit ab, string tag);
    bit exp;
    @(negedge clk);
    iss_vld = iv; iss_cls = 5'(ip); iss_dst = BA'(id); use_cls = 3'(c);
    src_a = BA'(sa); src_a_vld = va; src_a_addr = aa;
    src_b = BA'(sb); src_b_vld = vb; src_b_addr = ab;
    #5;
    exp = src_busy(iv, ip, id, c, sa, va, aa) || src_busy(iv, ip, id, c, sb, vb, ab);
    checks++;
    if (stall !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d prod=%0d cons=%0d stall=%0b expected=%0b",
               tag, cyc, ip, c, stall, exp);
    end
    if (iv) begin itime[id] = cyc; pcls[id] = ip; end
    @(posedge clk);
    cyc++;
  endtask

  task automatic sweep(int p, int c, bit ad, int d, int span, string tag);
    step(1, p, d, c, d, 1, ad, 0, 0, 0, tag);
    for (int k = 1; k <= span; k++) step(0, 0, 0, c, d, 1, ad, 0, 0, 0, tag);
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < BN; i++) begin itime[i] = -1000; pcls[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    // R1: every register ready for every consumer kind
    for (int r = 0; r < BN; r++) begin
      step(0, 0, 0, 4, r, 1, 1, r, 1, 0, "R1");
      step(0, 0, 0, 2, r, 1, 0, (r + 1) % BN, 1, 0, "R1");
    end
    // R3
    sweep(0, 4, 1, 1, 5, "R3"); sweep(0, 4, 0, 2, 3, "R3"); sweep(0, 0, 0, 3, 3, "R3");
    // R4
    sweep(1, 4, 1, 4, 7, "R4"); sweep(1, 0, 0, 5, 3, "R4"); sweep(1, 4, 0, 6, 3, "R4");
    // R5
    sweep(2, 4, 1, 7, 9, "R5"); sweep(2, 0, 0, 0, 5, "R5"); sweep(2, 4, 0, 1, 5, "R5");
    sweep(3, 2, 0, 2, 6, "R5"); sweep(3, 3, 0, 3, 6, "R5");
    sweep(3, 0, 0, 4, 6, "R5"); sweep(3, 4, 1, 5, 9, "R5");
    // R6
    sweep(4, 1, 0, 6, 6, "R6"); sweep(4, 2, 0, 7, 5, "R6");
    sweep(4, 3, 0, 0, 5, "R6"); sweep(4, 0, 0, 1, 6, "R6");
    // R7
    sweep(5, 0, 0, 2, 6, "R7"); sweep(6, 1, 0, 3, 10, "R7");
    sweep(7, 4, 1, 4, 7, "R7"); sweep(8, 4, 1, 5, 3, "R7"); sweep(8, 0, 0, 6, 3, "R7");
    // R8
    for (int p = 9; p <= 16; p++) sweep(p, p % 5, p[0], p % BN, 42, "R8");
    // R9: address flag ignored outside memory class; codes 5..7 act as execute
    sweep(1, 6, 1, 2, 6, "R9"); sweep(1, 0, 1, 3, 6, "R9"); sweep(3, 7, 1, 4, 6, "R9");
    // R10: invalid source ignored, OR of two sources
    step(1, 12, 5, 0, 5, 0, 0, 5, 0, 0, "R10");
    step(0, 0, 0, 0, 5, 0, 0, 6, 1, 0, "R10");
    step(0, 0, 0, 0, 6, 1, 0, 5, 1, 0, "R10");
    step(0, 0, 0, 0, 5, 1, 0, 6, 1, 0, "R10");
    // R11: shorter replaces longer, then longer replaces shorter
    step(1, 10, 6, 0, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 6, 1, 0, 0, 0, 0, "R11");
    sweep(1, 0, 0, 6, 4, "R11");
    step(1, 1, 7, 0, 0, 0, 0, 0, 0, 0, "R11");
    sweep(9, 0, 0, 7, 26, "R11");
    // R12: other registers unaffected
    step(1, 12, 3, 0, 4, 1, 0, 2, 1, 1, "R12");
    for (int k = 0; k < 6; k++) step(0, 0, 0, 4, 4, 1, 1, 3, k[0], 1, "R12");
    // R2: random traffic
    for (int n = 0; n < 3000; n++) begin
      int rv;
      rv = $urandom;
      step(rv[0] | rv[1], (rv >> 2) % 17, (rv >> 8) % BN, (rv >> 11) % 8,
           (rv >> 14) % BN, rv[17], rv[18], (rv >> 19) % BN, rv[22], rv[23], "R2");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule